// File: doc/BRIEF.md
# DRAM Row-Activate Admission Checker

This block decides the earliest cycle at which a row-activate command may legally go out to one bank of a multi-bank DRAM. A scheduler presents a bank, a row and a proposed cycle. The block applies the following checks in a fixed order, and each check can only push the cycle later:

1. The command previously recorded on that bank must have closed the bank, and it must have finished.
2. The minimum spacing between activates to the same bank.
3. The limit on how many activates may fall in a rolling window.
4. The minimum spacing to every activate it is still tracking.
5. The first free cycle on the command bus, taken from a calendar that a neighbouring block supplies.

The result appears one cycle later, together with the earliest cycle for a column command to the opened row and an error flag. The error flag marks an activate that follows a command which left the bank open.

When a request is marked as a commit and is legal, the block records it. It stores the activate time, notes the row as open for that bank, and pushes the time into a small history of recent activates. Other commands on the bank arrive on a separate note port as a kind code and a completion cycle. Row state can be read back through a registered query port. A request without the commit flag is a probe: it returns the same answer and leaves every piece of state unchanged.

Top module: `act_admit`

## Requirements
- R1: Note kind codes are PRE=0, PREA=1, REF=2, RDA=3, WRA=4, RD=5, WR=6. A committed activate records kind 7. A request raises `res_err` when its bank has a recorded command of kind 5, 6 or 7. A bank with no recorded command, or whose last command has kind 0 to 4, is legal. An erroneous request is never committed.
- R2: The issue cycle is never earlier than the completion cycle of the command last recorded on the bank.
- R3: The issue cycle is at least `T_RC` (default 9) after the previous committed activate to the same bank.
- R4: The history holds the last `N_ACT` (default 2) committed activate cycles. Once it is full, the issue cycle is at least the oldest entry plus `T_TAW` (default 48).
- R5: After the window check, while any tracked activate `e` satisfies |cycle − e| < `T_RRD` (default 2), the cycle moves to `e + T_RRD`.
- R6: `res_cycle` is never below `req_cycle`. `res_rw_cycle` equals `res_cycle + T_RCD` (default 3). Results are registered and appear one cycle after the request.
- R7: Bit i of `cal_busy` marks cycle `cal_base + i` as taken. The result is the first cycle at or after the candidate whose bit is clear. A candidate outside `[cal_base, cal_base+CAL_N)` is kept. If every later bit in the window is set, the result is `cal_base + CAL_N`.
- R8: A committed activate marks its bank open with the given row. `q_open` and `q_row` show the state of `q_bank` one cycle after it is presented.
- R9: Notes of kind 0, 2, 3 or 4 close their bank. Kind 1 closes every bank and records itself on all of them. Kinds 5 and 6 leave the row open.
- R10: A note and a request in the same cycle: the request is judged with the note already applied, including a note of kind 1 aimed at another bank.
- R11: After reset, `res_valid`, `res_err` and `q_open` are 0, no bank has history, and the activate history is empty.
- R12: A request with `req_commit` low changes no state. A repeated identical probe returns the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Activate request present |
| req_commit | input | 1 | Record the activate if legal |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_cycle | input | CYC_W | Proposed issue cycle |
| note_valid | input | 1 | Another command on a bank to record |
| note_kind | input | 3 | Kind code of the noted command |
| note_bank | input | BANK_W | Bank of the noted command |
| note_end | input | CYC_W | Completion cycle of the noted command |
| cal_base | input | CYC_W | Cycle of calendar bit 0 |
| cal_busy | input | CAL_N | Command-bus occupancy map |
| q_bank | input | BANK_W | Bank to read row state for |
| res_valid | output | 1 | Result present |
| res_cycle | output | CYC_W | Admitted issue cycle |
| res_rw_cycle | output | CYC_W | Earliest column-command cycle |
| res_err | output | 1 | Illegal predecessor |
| q_row | output | ROW_W | Open row of queried bank |
| q_open | output | 1 | Queried bank has an open row |

## Verification
Two functions can land in the same cycle: recording a note, and judging or committing an activate. The bench drives both together on the same bank, and a bank-wide close aimed at another bank together with a request. It then checks that the admitted cycle respects the note's completion time and that the committed activate, not the note, is the state left behind. A reference model in the bench applies the note first, evaluates the request against the result, and compares every result field and later query.

// File: rtl/act_admit_pkg.sv
package act_admit_pkg;
  typedef enum logic [2:0] {
    K_PRE  = 3'd0,
    K_PREA = 3'd1,
    K_REF  = 3'd2,
    K_RDA  = 3'd3,
    K_WRA  = 3'd4,
    K_RD   = 3'd5,
    K_WR   = 3'd6,
    K_ACT  = 3'd7
  } cmd_kind_e;

  // A kind that leaves its bank precharged: the only legal predecessors
  function automatic logic kind_closes(cmd_kind_e k);
    return (k == K_PRE) || (k == K_PREA) || (k == K_REF) ||
           (k == K_RDA) || (k == K_WRA);
  endfunction
endpackage

// File: rtl/act_bank_hist.sv
module act_bank_hist
  import act_admit_pkg::*;
#(
  parameter int N_BANK = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int CYC_W  = 16,
  parameter int T_RCD  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              note_valid,
  input  cmd_kind_e         note_kind,
  input  logic [BANK_W-1:0] note_bank,
  input  logic [CYC_W-1:0]  note_end,
  input  logic [BANK_W-1:0] look_bank,
  input  logic              commit_en,
  input  logic [ROW_W-1:0]  commit_row,
  input  logic [CYC_W-1:0]  commit_cycle,
  input  logic [BANK_W-1:0] q_bank,
  output logic              pred_has,
  output cmd_kind_e         pred_kind,
  output logic [CYC_W-1:0]  pred_end,
  output logic              act_has,
  output logic [CYC_W-1:0]  act_last,
  output logic [ROW_W-1:0]  q_row,
  output logic              q_open
);
  localparam logic [CYC_W-1:0] RCD_C = CYC_W'(T_RCD);

  logic [N_BANK-1:0] h_has, a_has, open_q;
  cmd_kind_e         h_kind [N_BANK];
  logic [CYC_W-1:0]  h_end  [N_BANK];
  logic [CYC_W-1:0]  a_last [N_BANK];
  logic [ROW_W-1:0]  row_mem [N_BANK];

  logic note_ok, note_hits;
  assign note_ok   = note_valid && (note_kind != K_ACT);
  assign note_hits = note_ok && ((note_kind == K_PREA) || (note_bank == look_bank));

  // View of the looked-up bank with a same-cycle note already applied
  always_comb begin
    if (note_hits) begin
      pred_has  = 1'b1;
      pred_kind = note_kind;
      pred_end  = note_end;
    end else begin
      pred_has  = h_has[look_bank];
      pred_kind = h_kind[look_bank];
      pred_end  = h_end[look_bank];
    end
    act_has  = a_has[look_bank];
    act_last = a_last[look_bank];
  end

  // Per-bank history; a commit is written after the note so it wins
  always_ff @(posedge clk) begin
    if (rst) begin
      h_has  <= '0;
      a_has  <= '0;
      open_q <= '0;
      for (int b = 0; b < N_BANK; b++) begin
        h_kind[b] <= K_PRE;
        h_end[b]  <= '0;
        a_last[b] <= '0;
      end
    end else begin
      if (note_ok) begin
        for (int b = 0; b < N_BANK; b++) begin
          if ((note_kind == K_PREA) || (BANK_W'(b) == note_bank)) begin
            h_has[b]  <= 1'b1;
            h_kind[b] <= note_kind;
            h_end[b]  <= note_end;
            if (kind_closes(note_kind)) open_q[b] <= 1'b0;
          end
        end
      end
      if (commit_en) begin
        h_has[look_bank]  <= 1'b1;
        h_kind[look_bank] <= K_ACT;
        h_end[look_bank]  <= commit_cycle + RCD_C;
        a_has[look_bank]  <= 1'b1;
        a_last[look_bank] <= commit_cycle;
        open_q[look_bank] <= 1'b1;
      end
    end
  end

  // Row table: single write port, registered read, no reset
  always_ff @(posedge clk) begin
    if (commit_en) row_mem[look_bank] <= commit_row;
    q_row <= row_mem[q_bank];
  end

  always_ff @(posedge clk) begin
    if (rst) q_open <= 1'b0;
    else     q_open <= open_q[q_bank];
  end

  AST_COMMIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    commit_en |-> (!pred_has || kind_closes(pred_kind)));  // R1
  AST_COMMIT_OPENS: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> open_q[$past(look_bank)]);  // R8
endmodule

// File: rtl/act_window.sv
module act_window #(
  parameter int N_ACT = 2,
  parameter int CYC_W = 16,
  parameter int T_RRD = 2,
  parameter int T_TAW = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] cand_in,
  input  logic             push_en,
  input  logic [CYC_W-1:0] push_cycle,
  output logic [CYC_W-1:0] cand_out
);
  localparam int PTR_W = (N_ACT > 1) ? $clog2(N_ACT) : 1;
  localparam logic [CYC_W-1:0] RRD_C = CYC_W'(T_RRD);
  localparam logic [CYC_W-1:0] TAW_C = CYC_W'(T_TAW);

  logic [CYC_W-1:0] slot [N_ACT];
  logic [N_ACT-1:0] vld;
  logic [PTR_W-1:0] wptr;
  logic             full;
  logic [CYC_W-1:0] oldest_lim;

  assign full       = &vld;
  assign oldest_lim = slot[wptr] + TAW_C;

  // Window limit, then spacing passes; each pass clears at least one entry
  always_comb begin
    logic [CYC_W-1:0] c;
    c = cand_in;
    if (full && (c < oldest_lim)) c = oldest_lim;
    for (int p = 0; p < N_ACT; p++) begin
      for (int e = 0; e < N_ACT; e++) begin
        if (vld[e] && (c + RRD_C > slot[e]) && (slot[e] + RRD_C > c))
          c = slot[e] + RRD_C;
      end
    end
    cand_out = c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      wptr <= '0;
      for (int e = 0; e < N_ACT; e++) slot[e] <= '0;
    end else if (push_en) begin
      slot[wptr] <= push_cycle;
      vld[wptr]  <= 1'b1;
      wptr       <= (wptr == PTR_W'(N_ACT - 1)) ? '0 : wptr + 1'b1;
    end
  end

  AST_TAW_HONORED: assert property (@(posedge clk) disable iff (rst)
    (push_en && full) |-> (push_cycle >= oldest_lim));  // R4
  AST_PUSH_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    push_en |-> (push_cycle >= cand_out));  // R5
endmodule

// File: rtl/act_bus_slot.sv
module act_bus_slot #(
  parameter int CYC_W = 16,
  parameter int CAL_N = 16
) (
  input  logic [CYC_W-1:0] cand,
  input  logic [CYC_W-1:0] cal_base,
  input  logic [CAL_N-1:0] cal_busy,
  output logic [CYC_W-1:0] slot_cycle
);
  localparam logic [CYC_W-1:0] SPAN_C = CYC_W'(CAL_N);

  logic [CYC_W-1:0] off;
  assign off = cand - cal_base;

  // Descending scan so the lowest free bit at or after the offset wins
  always_comb begin
    if ((cand < cal_base) || (cand >= cal_base + SPAN_C)) begin
      slot_cycle = cand;
    end else begin
      slot_cycle = cal_base + SPAN_C;
      for (int i = CAL_N - 1; i >= 0; i--) begin
        if ((CYC_W'(i) >= off) && !cal_busy[i])
          slot_cycle = cal_base + CYC_W'(i);
      end
    end
  end
endmodule

// File: rtl/act_admit.sv
module act_admit
  import act_admit_pkg::*;
#(
  parameter int N_BANK = 8,
  parameter int ROW_W  = 14,
  parameter int CYC_W  = 16,
  parameter int N_ACT  = 2,
  parameter int T_RC   = 9,
  parameter int T_RRD  = 2,
  parameter int T_TAW  = 48,
  parameter int T_RCD  = 3,
  parameter int CAL_N  = 16,
  localparam int BANK_W = $clog2(N_BANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_commit,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [CYC_W-1:0]  req_cycle,
  input  logic              note_valid,
  input  logic [2:0]        note_kind,
  input  logic [BANK_W-1:0] note_bank,
  input  logic [CYC_W-1:0]  note_end,
  input  logic [CYC_W-1:0]  cal_base,
  input  logic [CAL_N-1:0]  cal_busy,
  input  logic [BANK_W-1:0] q_bank,
  output logic              res_valid,
  output logic [CYC_W-1:0]  res_cycle,
  output logic [CYC_W-1:0]  res_rw_cycle,
  output logic              res_err,
  output logic [ROW_W-1:0]  q_row,
  output logic              q_open
);
  localparam int CAL_W = (CAL_N > 1) ? $clog2(CAL_N) : 1;
  localparam logic [CYC_W-1:0] RC_C   = CYC_W'(T_RC);
  localparam logic [CYC_W-1:0] RCD_C  = CYC_W'(T_RCD);
  localparam logic [CYC_W-1:0] SPAN_C = CYC_W'(CAL_N);

  logic             pred_has, act_has;
  cmd_kind_e        pred_kind;
  logic [CYC_W-1:0] pred_end, act_last;
  logic [CYC_W-1:0] c_pred, c_rc, c_win, c_slot;
  logic             illegal, commit_en;

  assign illegal   = pred_has && !kind_closes(pred_kind);
  assign commit_en = req_valid && req_commit && !illegal;

  act_bank_hist #(
    .N_BANK(N_BANK), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .CYC_W(CYC_W), .T_RCD(T_RCD)
  ) u_hist (
    .clk(clk), .rst(rst),
    .note_valid(note_valid), .note_kind(cmd_kind_e'(note_kind)),
    .note_bank(note_bank), .note_end(note_end),
    .look_bank(req_bank), .commit_en(commit_en),
    .commit_row(req_row), .commit_cycle(c_slot),
    .q_bank(q_bank),
    .pred_has(pred_has), .pred_kind(pred_kind), .pred_end(pred_end),
    .act_has(act_has), .act_last(act_last),
    .q_row(q_row), .q_open(q_open)
  );

  // Same-bank limits: predecessor completion, then activate-to-activate
  always_comb begin
    c_pred = req_cycle;
    if (pred_has && (pred_end > c_pred)) c_pred = pred_end;
    c_rc = c_pred;
    if (act_has && (act_last + RC_C > c_rc)) c_rc = act_last + RC_C;
  end

  act_window #(
    .N_ACT(N_ACT), .CYC_W(CYC_W), .T_RRD(T_RRD), .T_TAW(T_TAW)
  ) u_win (
    .clk(clk), .rst(rst),
    .cand_in(c_rc), .push_en(commit_en), .push_cycle(c_slot),
    .cand_out(c_win)
  );

  act_bus_slot #(.CYC_W(CYC_W), .CAL_N(CAL_N)) u_slot (
    .cand(c_win), .cal_base(cal_base), .cal_busy(cal_busy),
    .slot_cycle(c_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_cycle    <= '0;
      res_rw_cycle <= '0;
      res_err      <= 1'b0;
    end else begin
      res_valid    <= req_valid;
      res_cycle    <= c_slot;
      res_rw_cycle <= c_slot + RCD_C;
      res_err      <= req_valid && illegal;
    end
  end

  logic             slot_in_win;
  logic [CYC_W-1:0] slot_off;
  assign slot_in_win = (c_slot >= cal_base) && (c_slot < cal_base + SPAN_C);
  assign slot_off    = c_slot - cal_base;

  AST_NEVER_EARLY: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_cycle >= $past(req_cycle)));  // R6
  AST_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && slot_in_win) |-> !cal_busy[slot_off[CAL_W-1:0]]);  // R7
  AST_ERR_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    res_err |-> res_valid);  // R1
endmodule

// File: tb/act_admit_bench.sv
module act_admit_bench;
  localparam int NB = 8, RW = 14, CW = 16, NA = 2;
  localparam int TRC = 9, TRRD = 2, TTAW = 48, TRCD = 3, CN = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_commit = 0, note_valid = 0;
  logic [2:0] req_bank = 0, note_bank = 0, q_bank = 0;
  logic [RW-1:0] req_row = 0;
  logic [CW-1:0] req_cycle = 0, note_end = 0, cal_base = 0;
  logic [2:0] note_kind = 0;
  logic [CN-1:0] cal_busy = 0;
  logic res_valid, res_err, q_open;
  logic [CW-1:0] res_cycle, res_rw_cycle;
  logic [RW-1:0] q_row;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  act_admit u_act_admit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_commit(req_commit),
    .req_bank(req_bank), .req_row(req_row), .req_cycle(req_cycle),
    .note_valid(note_valid), .note_kind(note_kind), .note_bank(note_bank),
    .note_end(note_end), .cal_base(cal_base), .cal_busy(cal_busy),
    .q_bank(q_bank), .res_valid(res_valid), .res_cycle(res_cycle),
    .res_rw_cycle(res_rw_cycle), .res_err(res_err), .q_row(q_row),
    .q_open(q_open)
  );

  // Reference model
  bit m_has[NB], m_ahas[NB], m_open[NB];
  int m_kind[NB], m_end[NB], m_alast[NB], m_row[NB];
  int m_slot[NA];
  bit m_vld[NA];
  int m_wp;

  function automatic void m_reset();
    for (int b = 0; b < NB; b++) begin
      m_has[b] = 0; m_ahas[b] = 0; m_open[b] = 0; m_kind[b] = 0;
      m_end[b] = 0; m_alast[b] = 0; m_row[b] = 0;
    end
    for (int e = 0; e < NA; e++) begin m_slot[e] = 0; m_vld[e] = 0; end
    m_wp = 0;
  endfunction

  function automatic bit closes(int k);
    return (k <= 4);
  endfunction

  function automatic void m_note(int k, int b, int e);
    for (int i = 0; i < NB; i++)
      if (k == 1 || i == b) begin
        m_has[i] = 1; m_kind[i] = k; m_end[i] = e;
        if (closes(k)) m_open[i] = 0;
      end
  endfunction

  function automatic int m_eval(int b, int p, int base, logic [CN-1:0] busy);
    int c;
    bit full, moved;
    c = p;
    if (m_has[b] && m_end[b] > c) c = m_end[b];
    if (m_ahas[b] && m_alast[b] + TRC > c) c = m_alast[b] + TRC;
    full = 1;
    for (int e = 0; e < NA; e++) if (!m_vld[e]) full = 0;
    if (full && m_slot[m_wp] + TTAW > c) c = m_slot[m_wp] + TTAW;
    moved = 1;
    while (moved) begin
      moved = 0;
      for (int e = 0; e < NA; e++)
        if (m_vld[e] && c - m_slot[e] < TRRD && m_slot[e] - c < TRRD) begin
          c = m_slot[e] + TRRD; moved = 1;
        end
    end
    if (c >= base && c < base + CN) begin
      while (c < base + CN && busy[c - base]) c++;
    end
    return c;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit rv, bit rc, int rb, int rrow, int rcyc,
                      bit nv, int nk, int nb, int ne,
                      int cb, logic [CN-1:0] busy, string tag);
    int exp_c;
    bit exp_e;
    req_valid = rv; req_commit = rc; req_bank = 3'(rb); req_row = RW'(rrow);
    req_cycle = CW'(rcyc); note_valid = nv; note_kind = 3'(nk);
    note_bank = 3'(nb); note_end = CW'(ne); cal_base = CW'(cb); cal_busy = busy;
    if (nv) m_note(nk, nb, ne);
    exp_c = 0; exp_e = 0;
    if (rv) begin
      exp_c = m_eval(rb, rcyc, cb, busy);
      exp_e = m_has[rb] && !closes(m_kind[rb]);
      if (rc && !exp_e) begin
        m_has[rb] = 1; m_kind[rb] = 7; m_end[rb] = exp_c + TRCD;
        m_ahas[rb] = 1; m_alast[rb] = exp_c; m_open[rb] = 1; m_row[rb] = rrow;
        m_slot[m_wp] = exp_c; m_vld[m_wp] = 1; m_wp = (m_wp + 1) % NA;
      end
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; note_valid = 0;
    chk(res_valid == rv, {tag, " valid"}, int'(res_valid), int'(rv));
    if (rv) begin
      chk(res_cycle == CW'(exp_c), {tag, " cycle"}, int'(res_cycle), exp_c);
      chk(res_rw_cycle == CW'(exp_c + TRCD), "R6 rw cycle", int'(res_rw_cycle), exp_c + TRCD);
      chk(res_err == exp_e, {tag, " err"}, int'(res_err), int'(exp_e));
    end
  endtask

  task automatic qcheck(int b, string tag);
    q_bank = 3'(b);
    @(posedge clk);
    @(negedge clk);
    chk(q_open == m_open[b], {tag, " open"}, int'(q_open), int'(m_open[b]));
    if (m_open[b]) chk(q_row == RW'(m_row[b]), {tag, " row"}, int'(q_row), m_row[b]);
  endtask

  task automatic do_reset();
    rst = 1; m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R11: reset state
    chk(res_valid == 0, "R11 valid", int'(res_valid), 0);
    chk(res_err == 0, "R11 err", int'(res_err), 0);
    qcheck(0, "R11");

    // Directed corner cases
    step(1,1,0,'h12,100, 0,0,0,0, 100,'0, "R8");
    qcheck(0, "R8");
    step(1,1,0,5,102, 0,0,0,0, 100,'0, "R1");          // act after act
    step(0,0,0,0,0, 1,0,0,106, 100,'0, "R9");           // PRE bank 0
    qcheck(0, "R9");
    step(1,1,0,7,103, 0,0,0,0, 100,'0, "R3");           // tRC + R2
    step(1,1,2,9,120, 1,2,2,130, 100,'0, "R10");        // note+req same cycle
    step(1,1,3,4,150, 0,0,0,0, 100,'0, "R4");           // window full

    do_reset();
    step(1,1,6,1,500, 0,0,0,0, 500,'0, "R5");
    step(1,0,7,2,501, 0,0,0,0, 500,'0, "R5");           // probe, spacing
    step(1,0,7,2,501, 0,0,0,0, 500,'0, "R12");          // same probe again
    qcheck(7, "R12");
    step(1,1,7,3,547, 0,0,0,0, 500,'0, "R5");
    step(1,1,5,4,548, 0,0,0,0, 500,'0, "R5");           // window then spacing
    step(1,1,1,6,600, 0,0,0,0, 598,16'h001C, "R7");     // busy slots
    step(1,0,2,6,610, 0,0,0,0, 600,16'hFFFF, "R7");     // all busy
    step(1,0,2,6,590, 0,0,0,0, 600,16'hFFFF, "R7");     // before window
    step(0,0,0,0,0, 1,1,6,700, 600,'0, "R9");           // PREA
    qcheck(1, "R9");
    qcheck(5, "R9");
    step(1,1,3,8,720, 1,1,0,700, 600,'0, "R10");        // PREA elsewhere + req
    step(0,0,0,0,0, 1,5,3,730, 600,'0, "R9");           // RD keeps row open
    qcheck(3, "R9");
    step(1,1,3,8,740, 0,0,0,0, 600,'0, "R1");           // act after RD

    // Constrained random
    begin
      int now;
      now = 1000;
      for (int it = 0; it < 600; it++) begin
        bit rv, rc, nv;
        int rb, nb, nk;
        now += $urandom_range(0, 12);
        rv = ($urandom_range(0, 9) < 7);
        rc = ($urandom_range(0, 9) < 7);
        nv = ($urandom_range(0, 9) < 4);
        rb = $urandom_range(0, NB-1);
        nb = ($urandom_range(0, 3) == 0) ? rb : $urandom_range(0, NB-1);
        nk = $urandom_range(0, 6);
        step(rv, rc, rb, $urandom_range(0, 16383), now + $urandom_range(0, 15),
             nv, nk, nb, now + $urandom_range(0, 20),
             now, CN'($urandom & $urandom), "R2 random");
        if (it % 25 == 0) qcheck($urandom_range(0, NB-1), "R8 random");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule